// File: doc/BRIEF.md
# Comparator interrupt flag controller

This block holds the 16-bit interrupt control register of an analog comparator. It watches the comparator's digital output, which arrives with no timing relation to the clock, and a reference-settled indication. From these it records three sticky events: an edge flag, an inverted-edge flag and a ready flag. A single edge-select input picks which transition of the output each of the two edge flags reacts to.

Software reads and writes the register through a simple synchronous port. There is one write strobe and data word, and read data is always presented. The register holds one enable bit per flag. The block drives a single registered interrupt request, which is high while any enabled flag is set. Flags are cleared only by software writing 0. A hardware event that arrives in the same cycle as such a write takes priority over it.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x0000 and `irq_o` is low.
- R2: Field layout: output-edge flag at bit 0, inverted-edge flag at bit 1, ready flag at bit 4, and their enables at bits 8, 9 and 12. All six are writable, and writing 1 to a flag bit sets it.
- R3: Bits 2, 3, 5 to 7, 10, 11 and 13 to 15 always read 0, whatever is written.
- R4: With `edge_sel_i` = 0, a rising comparator edge sets bit 0 and a falling edge sets bit 1.
- R5: With `edge_sel_i` = 1, a falling comparator edge sets bit 0 and a rising edge sets bit 1.
- R6: A set flag stays set until software writes 0 to it. No flag changes without a write or a hardware event.
- R7: If a hardware set event and a software write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R8: The ready flag sets on the rising edge of `ref_ready_i`. A level held high does not set it again after it is cleared.
- R9: `irq_o` equals, one clock later, the OR over the three pairs of (flag AND enable).
- R10: A comparator transition sampled at clock edge k sets its flag at edge k+2. It passes through a two-stage synchronizer and then one edge-compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Current register contents |
| cmp_out_i | input | 1 | Comparator digital output, asynchronous |
| edge_sel_i | input | 1 | Edge select for the two edge flags |
| ref_ready_i | input | 1 | Reference-settled indication, synchronous |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The assertions check every cycle that flags are sticky when nothing writes them, and that flags stay clear without an event or a write. They also check that a set event always leaves its flag high at the next edge, and that the interrupt request follows the enabled flags one cycle later. Only the bench scenarios can show which edge-select setting maps a rising or falling output edge to which flag. The same holds for the exact latency through the synchronizer, the reserved bits reading zero after writes of all ones, and the ready flag staying clear under a held-high indication.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned NUM_SRC = 3;

  localparam int unsigned SRC_OUT = 0;
  localparam int unsigned SRC_INV = 1;
  localparam int unsigned SRC_RDY = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  function automatic int unsigned flag_pos(input int unsigned src);
    case (src)
      SRC_OUT: flag_pos = 0;
      SRC_INV: flag_pos = 1;
      default: flag_pos = 4;
    endcase
  endfunction

  function automatic int unsigned en_pos(input int unsigned src);
    en_pos = flag_pos(src) + 8;
  endfunction

  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) begin
      m[flag_pos(s)] = 1'b1;
      m[en_pos(s)]   = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/cmp_irq_rst_sync.sv
module cmp_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_irq_sync.sv
module cmp_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_irq_edge.sv
module cmp_irq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = lvl_i;
    rise_o = lvl_i & ~prev_q;
    fall_o = ~lvl_i & prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end
endmodule

// File: rtl/cmp_irq_regs.sv
module cmp_irq_regs
  import cmp_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  src_vec_t wr_flag_i,
  input  src_vec_t wr_en_i,
  input  src_vec_t set_i,
  output src_vec_t flag_o,
  output src_vec_t en_o,
  output logic     irq_o
);
  src_vec_t flag_q, flag_d;
  src_vec_t en_q, en_d;
  logic     irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    if (wr_i) begin
      flag_d = wr_flag_i;
      en_d   = wr_en_i;
    end
    flag_d = flag_d | set_i;
    irq_d  = |(flag_q & en_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
      AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && flag_q[s]) |=> flag_q[s]); // R6
      AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && !set_i[s] && !flag_q[s]) |=> !flag_q[s]); // R6
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[s] |=> flag_q[s]); // R7
    end
  endgenerate

  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_o & en_o)) |=> irq_o); // R9
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flag_o & en_o)) |=> !irq_o); // R9
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             cmp_out_i,
  input  logic             edge_sel_i,
  input  logic             ref_ready_i,
  output logic             irq_o
);
  localparam logic [REG_W-1:0] LIVE = live_mask();

  logic     rst_int_n;
  logic     cmp_sync;
  logic     cmp_rise, cmp_fall;
  logic     rdy_rise, rdy_fall_unused;
  src_vec_t set_vec, wr_flag, wr_en, flag, en;
  logic     unused_wdata;

  cmp_irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_int_n)
  );

  cmp_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_int_n), .d_i(cmp_out_i), .q_o(cmp_sync)
  );

  cmp_irq_edge u_cmp_edge (
    .clk_i(clk_i), .rst_ni(rst_int_n), .lvl_i(cmp_sync),
    .rise_o(cmp_rise), .fall_o(cmp_fall)
  );

  cmp_irq_edge u_rdy_edge (
    .clk_i(clk_i), .rst_ni(rst_int_n), .lvl_i(ref_ready_i),
    .rise_o(rdy_rise), .fall_o(rdy_fall_unused)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_OUT] = edge_sel_i ? cmp_fall : cmp_rise;
    set_vec[SRC_INV] = edge_sel_i ? cmp_rise : cmp_fall;
    set_vec[SRC_RDY] = rdy_rise;
    for (int unsigned s = 0; s < NUM_SRC; s++) begin
      wr_flag[s] = reg_wdata_i[flag_pos(s)];
      wr_en[s]   = reg_wdata_i[en_pos(s)];
    end
  end

  assign unused_wdata = ^(reg_wdata_i & ~LIVE);

  cmp_irq_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .wr_i     (reg_wr_i),
    .wr_flag_i(wr_flag),
    .wr_en_i  (wr_en),
    .set_i    (set_vec),
    .flag_o   (flag),
    .en_o     (en),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) begin
      reg_rdata_o[flag_pos(s)] = flag[s];
      reg_rdata_o[en_pos(s)]   = en[s];
    end
  end

  AST_EDGE_SEL_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    cmp_rise |=> (edge_sel_i ? flag[SRC_INV] : flag[SRC_OUT]) | $past(edge_sel_i) != edge_sel_i); // R4 R5
endmodule

// File: tb/cmp_irq_ctrl_tb_top.sv
module cmp_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cmp = 1'b0;
  logic        sel = 1'b0;
  logic        rdy = 1'b0;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  cmp_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cmp_out_i(cmp), .edge_sel_i(sel),
    .ref_ready_i(rdy), .irq_o(irq)
  );

  // behavioural reference model
  logic        sq[$];
  logic        m_prev, m_rprev, m_irq;
  logic [15:0] m_reg;
  int          rcnt;

  task automatic model_clear();
    sq = {1'b0, 1'b0};
    m_prev = 0; m_rprev = 0; m_irq = 0; m_reg = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0;
      model_clear();
    end else if (rcnt < 2) begin
      rcnt++;
      model_clear();
    end else begin
      logic cur, up, dn, rr, nirq;
      cur = sq[0];
      up = cur && !m_prev;
      dn = !cur && m_prev;
      m_prev = cur;
      void'(sq.pop_front());
      sq.push_back(cmp);
      rr = rdy && !m_rprev;
      m_rprev = rdy;
      nirq = (m_reg[0] && m_reg[8]) || (m_reg[1] && m_reg[9]) || (m_reg[4] && m_reg[12]);
      if (wr) m_reg = wdata & 16'h1313;
      if (sel ? dn : up) m_reg[0] = 1'b1;
      if (sel ? up : dn) m_reg[1] = 1'b1;
      if (rr) m_reg[4] = 1'b1;
      m_irq = nirq;
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (rdata !== m_reg || irq !== m_irq) begin
      errors++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, rdata, irq, m_reg, m_irq);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [15:0] v);
    @(negedge clk); wr = 1'b1; wdata = v;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic direct_check(input string t, input logic [15:0] exp);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", t, rdata, exp);
    end
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(4);
    direct_check("R1", 16'h0000);

    tag = "R3";
    reg_write(16'hFFFF);
    direct_check("R2", 16'h1313);
    idle(2);
    reg_write(16'h0000);
    direct_check("R3", 16'h0000);

    tag = "R4";
    sel = 0;
    cmp = 1; idle(5);
    direct_check("R4", 16'h0001);
    cmp = 0; idle(5);
    direct_check("R4", 16'h0003);

    tag = "R9";
    reg_write(16'h0100);
    idle(3);
    reg_write(16'h0000);
    idle(2);

    tag = "R10";
    cmp = 1; idle(1);
    direct_check("R10", 16'h0000);
    idle(1);
    direct_check("R10", 16'h0000);
    idle(1);
    direct_check("R10", 16'h0001);
    reg_write(16'h0000);

    tag = "R5";
    sel = 1;
    cmp = 0; idle(5);
    direct_check("R5", 16'h0001);
    cmp = 1; idle(5);
    direct_check("R5", 16'h0003);

    tag = "R6";
    reg_write(16'h0203);
    idle(20);
    direct_check("R6", 16'h0203);
    reg_write(16'h0202);
    direct_check("R6", 16'h0202);
    reg_write(16'h0000);

    tag = "R7";
    sel = 0;
    cmp = 0; idle(5);
    reg_write(16'h0000);
    @(negedge clk); cmp = 1;
    for (int i = 0; i < 3; i++) begin
      wr = 1'b1; wdata = 16'h0000;
      @(negedge clk);
    end
    wr = 1'b0;
    direct_check("R7", 16'h0001);
    reg_write(16'h0000);

    tag = "R8";
    rdy = 1; idle(3);
    direct_check("R8", 16'h0010);
    reg_write(16'h1000);
    idle(10);
    direct_check("R8", 16'h1000);
    rdy = 0; idle(2);
    rdy = 1; idle(3);
    direct_check("R8", 16'h1010);
    idle(2);
    tag = "R2";
    reg_write(16'h0013);
    direct_check("R2", 16'h0013);
    reg_write(16'h0000);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule